// File: doc/BRIEF.md
# Acknowledge-Gated Command Batch Sequencer

This block sends a batch of slow-control command frames, one at a time, to a remote controller over a serial control channel. The frames are pre-loaded into a local command buffer. The host starts the batch with a single start strobe. The block then takes the next frame from the buffer and hands it to a frame transmitter. It holds back the frame after that until the remote side replies. If no reply comes within a fixed number of clock cycles, the command is abandoned and the block moves on. The batch ends when the command buffer runs dry.

Every reply that arrives goes into a small response buffer, which the host drains. A reply that arrives when no command is waiting for it is stored with a late tag. This covers a reply that turns up after its timeout.

While a batch is running, any host access is held off by a wait output. The wait releases only when the whole batch has finished, so the host stays in step with the hardware without polling. A batch that outlasts the host's own give-up time must tolerate the host retrying the access. The per-batch timeout count and a sticky timeout flag are presented as status outputs.

Top module: `cmd_batch_seq`

## Requirements
- R1: After reset, tx_valid, cmd_pop, host_wait, rsp_valid and to_flag are 0, and to_count is 0.
- R2: Frames are sent in command-buffer order, one buffer pop per frame. tx_valid stays high with tx_data unchanged until tx_ready is seen high.
- R3: After a frame is accepted, no further command is popped until a reply arrives or the timeout expires. A reply while waiting pops the next command in the cycle that follows.
- R4: If no reply arrives within TIMEOUT_CYC cycles of a frame's acceptance, the block moves to the next command, to_count increments (saturating) and to_flag sets. A new batch start clears both.
- R5: A reply in the last cycle of the wait window counts as an acknowledge and not as a timeout.
- R6: Every reply is stored in arrival order with rsp_late = 0 if a command was waiting for it, else rsp_late = 1. rsp_data returns the reply byte.
- R7: A reply that arrives while the response buffer holds RSP_DEPTH entries is discarded, and the stored entries are unchanged.
- R8: host_wait is high exactly when host_req is high and a batch is in progress (fetching, sending or waiting). It falls in the cycle after the batch finds the command buffer empty.
- R9: A start with an empty command buffer sends no frame and ends the batch after one cycle of host_wait.
- R10: A start strobe while a batch is in progress is ignored. In particular, it does not clear to_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batch_go | input | 1 | Start strobe for a batch |
| host_req | input | 1 | A host register access is pending |
| host_wait | output | 1 | Holds the host access off while a batch runs |
| cmd_empty | input | 1 | Command buffer is empty |
| cmd_data | input | CMD_W | Head entry of the command buffer (first-word fall-through) |
| cmd_pop | output | 1 | Removes the head entry of the command buffer |
| tx_valid | output | 1 | A frame is offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the frame |
| tx_data | output | CMD_W | Frame offered to the transmitter |
| rx_valid | input | 1 | A reply from the remote controller is present |
| rx_data | input | RSP_W | Reply contents |
| rsp_valid | output | 1 | Response buffer holds at least one entry |
| rsp_pop | input | 1 | Host removes the head response |
| rsp_data | output | RSP_W | Head response contents |
| rsp_late | output | 1 | Head response arrived with no command waiting |
| to_count | output | CNT_W | Timeouts in the current or last batch |
| to_flag | output | 1 | At least one timeout in the current or last batch |

## Verification
A reply and the expiry of the wait window can land on the same clock edge, and that is where these two functions collide. The bench sweeps the reply delay after each accepted frame from zero to two cycles past the window. It runs one single-command batch per delay, so the delay equal to the window's last cycle drives the reply exactly on the expiry edge. For every delay, the expected timeout count, the late tag of the stored reply and the host wait level on the reply cycle are computed from the delay alone. At the boundary, the bench expects an acknowledge: no timeout is counted and the reply is not tagged late.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_SEND = 3'd2,
    ST_WAIT = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic run,
  output logic expired
);
  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LAST);
  assign cnt_en  = launch | (run & ~expired);

  always_comb begin
    if (launch) cnt_d = '0;
    else        cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cmd_empty,
  input  logic tx_ready,
  input  logic rx_valid,
  input  logic tmo,
  output logic cmd_pop,
  output logic sending,
  output logic waiting,
  output logic launch,
  output logic tmo_evt,
  output logic clr,
  output logic busy
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go) st_d = ST_LOAD;
      ST_LOAD: st_d = cmd_empty ? ST_DONE : ST_SEND;
      ST_SEND: if (tx_ready) st_d = ST_WAIT;
      ST_WAIT: if (rx_valid || tmo) st_d = ST_LOAD;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cmd_pop = (st_q == ST_LOAD) & ~cmd_empty;
  assign sending = (st_q == ST_SEND);
  assign waiting = (st_q == ST_WAIT);
  assign launch  = sending & tx_ready;
  assign tmo_evt = waiting & ~rx_valid & tmo;
  assign clr     = (st_q == ST_IDLE) & go;
  assign busy    = (st_q == ST_LOAD) | sending | waiting;
endmodule

// File: rtl/seq_rsp_fifo.sv
module seq_rsp_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         full, empty, do_wr, do_rd;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW-1:0] == rp_q[AW-1:0]) & (wp_q[AW] != rp_q[AW]);
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;
  assign valid = ~empty;
  assign rdata = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmd_batch_seq.sv
module cmd_batch_seq #(
  parameter int CMD_W       = 32,
  parameter int RSP_W       = 32,
  parameter int TIMEOUT_CYC = 50000,
  parameter int RSP_DEPTH   = 8,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             batch_go,
  input  logic             host_req,
  output logic             host_wait,
  input  logic             cmd_empty,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             cmd_pop,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [CMD_W-1:0] tx_data,
  input  logic             rx_valid,
  input  logic [RSP_W-1:0] rx_data,
  output logic             rsp_valid,
  input  logic             rsp_pop,
  output logic [RSP_W-1:0] rsp_data,
  output logic             rsp_late,
  output logic [CNT_W-1:0] to_count,
  output logic             to_flag
);
  localparam int EW = RSP_W + 1;

  logic waiting, launch, tmo, tmo_evt, clr, busy;
  logic [CMD_W-1:0] frame_q;
  logic [EW-1:0]    rsp_word;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, stat_en;

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(batch_go), .cmd_empty(cmd_empty),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .tmo(tmo),
    .cmd_pop(cmd_pop), .sending(tx_valid), .waiting(waiting),
    .launch(launch), .tmo_evt(tmo_evt), .clr(clr), .busy(busy)
  );

  seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(waiting), .expired(tmo)
  );

  seq_rsp_fifo #(.W(EW), .DEPTH(RSP_DEPTH)) u_rsp (
    .clk(clk), .rst_n(rst_n), .push(rx_valid),
    .wdata({~waiting, rx_data}), .pop(rsp_pop),
    .valid(rsp_valid), .rdata(rsp_word)
  );

  // frame holding register, loaded on each buffer pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_q <= '0;
    else if (cmd_pop) frame_q <= cmd_data;
  end

  // timeout statistics: cleared by an accepted start, bumped per abandoned command
  assign stat_en = clr | tmo_evt;

  always_comb begin
    if (clr) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else begin
      cnt_d  = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (stat_en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign tx_data   = frame_q;
  assign host_wait = host_req & busy;
  assign rsp_data  = rsp_word[RSP_W-1:0];
  assign rsp_late  = rsp_word[RSP_W];
  assign to_count  = cnt_q;
  assign to_flag   = flag_q;
endmodule

// File: rtl/cmd_batch_seq_chk.sv
module cmd_batch_seq_chk #(
  parameter int CMD_W = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_wait,
  input logic             cmd_empty,
  input logic             cmd_pop,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [CMD_W-1:0] tx_data,
  input logic             rsp_valid,
  input logic             rsp_pop,
  input logic [CNT_W-1:0] to_count,
  input logic             to_flag
);
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> !cmd_empty);

  assert_no_pop_while_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_pop);

  assert_flag_has_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> (to_count != '0));

  assert_rsp_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pop) |=> rsp_valid);

  assert_wait_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_wait |-> host_req);
endmodule

bind cmd_batch_seq cmd_batch_seq_chk #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cmd_batch_seq.sv
module sim_cmd_batch_seq;
  localparam int TO = 6;
  localparam int DEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic batch_go = 1'b0, host_req = 1'b0, tx_ready = 1'b1;
  logic rx_valid = 1'b0, rsp_pop = 1'b0;
  logic [7:0] rx_data = '0;
  logic host_wait, cmd_pop, tx_valid, rsp_valid, rsp_late, to_flag;
  logic [7:0] tx_data, rsp_data, to_count;
  logic cmd_empty;
  logic [7:0] cmd_data;

  logic [7:0] cq [64];
  int head = 0, tail = 0, n_tx = 0;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign cmd_empty = (head == tail);
  assign cmd_data  = cq[head % 64];

  always @(posedge clk) begin
    if (cmd_pop) head <= head + 1;
    if (tx_valid && tx_ready) n_tx <= n_tx + 1;
  end

  cmd_batch_seq #(.CMD_W(8), .RSP_W(8), .TIMEOUT_CYC(TO), .RSP_DEPTH(DEP), .CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .batch_go(batch_go), .host_req(host_req),
    .host_wait(host_wait), .cmd_empty(cmd_empty), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rsp_valid(rsp_valid), .rsp_pop(rsp_pop), .rsp_data(rsp_data),
    .rsp_late(rsp_late), .to_count(to_count), .to_flag(to_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_cmd(input logic [7:0] v);
    cq[tail % 64] = v;
    tail++;
  endtask

  task automatic pulse_go();
    batch_go = 1'b1;
    tick();
    batch_go = 1'b0;
  endtask

  task automatic wait_tx();
    for (int k = 0; k < 40; k++) begin
      if (tx_valid) break;
      tick();
    end
  endtask

  task automatic send_rx(input logic [7:0] v);
    rx_valid = 1'b1;
    rx_data  = v;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [7:0] d, input bit late, input string req);
    check(rsp_valid == 1'b1, req, rsp_valid, 1);
    check(rsp_data == d, req, rsp_data, d);
    check(rsp_late == late, req, rsp_late, late);
    rsp_pop = 1'b1;
    tick();
    rsp_pop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int tx0;
    host_req = 1'b1;
    tick();
    // R1: reset state
    check(tx_valid == 0 && cmd_pop == 0 && host_wait == 0, "R1", tx_valid, 0);
    check(rsp_valid == 0 && to_flag == 0 && to_count == 0, "R1", to_count, 0);
    rst_n = 1'b1;
    tick();
    check(host_wait == 0 && tx_valid == 0, "R1", host_wait, 0);

    // R5/R4/R6/R8: one-command batches, reply delay swept across the window edge
    for (int d = 0; d <= TO + 1; d++) begin
      push_cmd(8'(d + 1));
      pulse_go();
      wait_tx();
      check(tx_data == 8'(d + 1), "R2", tx_data, d + 1);
      tick();
      repeat (d) tick();
      check(host_wait == (d <= TO), "R8", host_wait, (d <= TO));
      send_rx(8'(d + 1) ^ 8'hA5);
      repeat (4) tick();
      check(host_wait == 0, "R8", host_wait, 0);
      check(to_count == ((d >= TO) ? 1 : 0), (d == TO - 1) ? "R5" : "R4", to_count, (d >= TO));
      check(to_flag == (d >= TO), "R4", to_flag, (d >= TO));
      pop_expect(8'(d + 1) ^ 8'hA5, (d >= TO), "R6");
      check(rsp_valid == 0, "R6", rsp_valid, 0);
    end

    // R2/R3: three commands, first transmitter stall, acked after 2 cycles
    push_cmd(8'h31); push_cmd(8'h32); push_cmd(8'h33);
    tx0 = head;
    tx_ready = 1'b0;
    pulse_go();
    for (int i = 0; i < 3; i++) begin
      wait_tx();
      check(tx_data == 8'(8'h31 + i), "R2", tx_data, 8'h31 + i);
      check(head == tx0 + i + 1, "R2", head - tx0, i + 1);
      if (i == 0) begin
        repeat (3) begin
          tick();
          check(tx_valid == 1 && tx_data == 8'h31, "R2", tx_valid, 1);
        end
        tx_ready = 1'b1;
      end
      tick();
      repeat (2) tick();
      check(head == tx0 + i + 1 && cmd_pop == 0, "R3", head - tx0, i + 1);
      send_rx(8'(8'h41 + i));
      if (i < 2) check(cmd_pop == 1, "R3", cmd_pop, 1);
    end
    repeat (4) tick();
    check(to_count == 0 && host_wait == 0, "R3", to_count, 0);
    pop_expect(8'h41, 0, "R6");
    pop_expect(8'h42, 0, "R6");
    pop_expect(8'h43, 0, "R6");

    // R4/R10: two silent commands, extra start mid-batch
    tx0 = n_tx;
    push_cmd(8'h51); push_cmd(8'h52);
    pulse_go();
    wait_tx();
    repeat (3) tick();
    pulse_go();
    repeat (3 * TO + 12) tick();
    check(n_tx - tx0 == 2, "R4", n_tx - tx0, 2);
    check(to_count == 2, "R10", to_count, 2);
    check(to_flag == 1, "R4", to_flag, 1);

    // R9/R4/R8: empty start clears stats, one cycle of wait, no frame
    tx0 = n_tx;
    pulse_go();
    check(host_wait == 1, "R8", host_wait, 1);
    check(to_count == 0 && to_flag == 0, "R4", to_count, 0);
    tick();
    check(host_wait == 0, "R9", host_wait, 0);
    repeat (3) tick();
    check(n_tx == tx0 && tx_valid == 0, "R9", n_tx - tx0, 0);

    // R7: overflow the response buffer with unsolicited replies
    for (int j = 0; j < DEP + 2; j++) send_rx(8'(8'h10 + j));
    for (int j = 0; j < DEP; j++) pop_expect(8'(8'h10 + j), 1, "R7");
    check(rsp_valid == 0, "R7", rsp_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule